// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block produces the once-per-line clamp strobe that a three-channel video digitizer uses to pin the black level of AC-coupled colour inputs. It runs entirely on the pixel clock. When the horizontal sync input leaves its active level, the block waits a programmed number of pixels and then drives the strobe for a programmed number of pixels. The timing places the strobe on the back porch, after sync has ended and before active video begins. All three colour channels share this single strobe.

The delay and the width are 8-bit values held in configuration registers outside the block. Both registers reset to 128. The block captures both values when it detects the sync trailing edge, so a register write that lands in the middle of a line leaves the current pulse untouched. A polarity bit sets which level of the sync input counts as active. A select input can route an externally supplied clamp signal to the strobe output in place of the internal pulse. A separate debug flag always shows the internally timed pulse.

The sync input must already be synchronous to the pixel clock. It is registered once before edge detection.

Top module: `bp_clamp_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pulse_active` is low after that edge, and any pending or running pulse is discarded.
- R2: Call the normalized sync level `hsync_in XOR hs_active_low`. Suppose it is sampled active at edge n-1 and inactive at edge n. Then `pulse_active` is high after edges n+1+D through n+D+W, and low after the edges around that window. D and W are the captured delay and width.
- R3: A captured width of 0 produces no pulse for that line.
- R4: A captured delay of 0 raises `pulse_active` right after edge n+1, the first edge after the trailing edge is detected.
- R5: `delay_cfg` and `width_cfg` are sampled at edge n+1 only. Changing them later in the line has no effect on the pulse already being timed.
- R6: A new sync trailing edge restarts timing from that edge. A pending or running pulse from the earlier edge is abandoned at the new capture edge.
- R7: With `hs_active_low` = 1, a low level on `hsync_in` counts as sync active, so the trailing edge is a rising edge. With `hs_active_low` = 0, a high level counts as active, so the trailing edge is a falling edge.
- R8: `clamp_out` equals `ext_clamp_in` in the same cycle while `use_ext` = 1. It equals `pulse_active` while `use_ext` = 0.
- R9: Internal timing and `pulse_active` continue unchanged whatever the value of `use_ext`.
- R10: The maximum values are handled exactly: delay 255 and width 255 give a pulse from edge n+256 through edge n+510.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, synchronous to `clk` |
| hs_active_low | input | 1 | 1: sync is active low; 0: sync is active high |
| delay_cfg | input | 8 | Pixels from the sync trailing edge to the start of the clamp |
| width_cfg | input | 8 | Clamp length in pixels; 0 disables the pulse |
| use_ext | input | 1 | 1 selects the external clamp for `clamp_out` |
| ext_clamp_in | input | 1 | Externally supplied clamp strobe |
| clamp_out | output | 1 | Clamp strobe shared by the three channels |
| pulse_active | output | 1 | Debug view of the internally timed pulse |

## Verification
The bench computes the expected pulse window from the edge index it observes at the ports and from the delay and width present at the capture edge. Directed lines cover the following cases, and random lines mix them:

- **Zero delay:** a design with an off-by-one here would start the pulse a cycle late.
- **Zero width:** a design that mishandles it would run a 256-pixel pulse.
- **Mid-line register writes:** a design that reads the live register values would stretch or move the pulse.
- **Lines short enough that a new trailing edge cuts a pulse:** a design that does not restart would keep the stale window.
- **Inverted sync polarity:** a wrong polarity would time the pulse from the leading edge.
- **Both maximum values:** a counter too narrow or a wrong compare would wrap early.

An external-select toggle and a reset issued in the middle of a pulse check that the output multiplexer and the reset clear the strobe.

// File: rtl/bp_clamp_pkg.sv
// Shared definitions for the back-porch clamp generator.
// Assumes: configuration values are unsigned pixel counts.
package bp_clamp_pkg;

    localparam int unsigned CFG_W = 8;

    // Phase of the per-line pulse timer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HOLD = 2'd2
    } clamp_phase_e;

endpackage

// File: rtl/bp_sync_edge.sv
// Normalizes the horizontal sync to active-high and flags the cycle in
// which its trailing edge is seen (one registered stage plus history).
// Assumes: hs_raw is already synchronous to clk.
module bp_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_raw,
    input  logic act_low,
    output logic trail
);

    logic hs_now_q;
    logic hs_prev_q;

    // Register the normalized sync level and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_now_q  <= 1'b0;
            hs_prev_q <= 1'b0;
        end else begin
            hs_now_q  <= hs_raw ^ act_low;
            hs_prev_q <= hs_now_q;
        end
    end

    // Trailing edge: active last sample, inactive this sample.
    always_comb begin
        trail = hs_prev_q & ~hs_now_q;
    end

endmodule

// File: rtl/bp_pulse_timer.sv
// Counts a delay then a width after each trailing-edge strobe and shows
// the pulse while counting the width. Values are captured at the strobe.
// Assumes: trail is a single-cycle strobe; a new strobe restarts timing.
module bp_pulse_timer
    import bp_clamp_pkg::*;
#(
    parameter int unsigned CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trail,
    input  logic [CNT_W-1:0] dly_in,
    input  logic [CNT_W-1:0] wid_in,
    output logic             active
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    clamp_phase_e     phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wid_q;

    // Phase and count sequencing; a trailing edge overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= ZERO;
            wid_q   <= ZERO;
        end else if (trail) begin
            wid_q <= wid_in;
            if (wid_in == ZERO) begin
                phase_q <= PH_IDLE;
                cnt_q   <= ZERO;
            end else if (dly_in == ZERO) begin
                phase_q <= PH_HOLD;
                cnt_q   <= wid_in;
            end else begin
                phase_q <= PH_WAIT;
                cnt_q   <= dly_in;
            end
        end else begin
            unique case (phase_q)
                PH_WAIT: begin
                    if (cnt_q == ONE) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= wid_q;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == ONE) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= ZERO;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= ZERO;
                end
            endcase
        end
    end

    // The pulse is visible during the width phase.
    always_comb begin
        active = (phase_q == PH_HOLD);
    end

endmodule

// File: rtl/bp_clamp_sel.sv
// Chooses the clamp strobe source: external pin or internal pulse.
// Assumes: the external clamp is already aligned to the pixel clock.
module bp_clamp_sel (
    input  logic use_ext,
    input  logic ext_clamp,
    input  logic int_pulse,
    output logic clamp
);

    // Same-cycle source selection.
    always_comb begin
        clamp = use_ext ? ext_clamp : int_pulse;
    end

endmodule

// File: rtl/bp_clamp_gen.sv
// Top of the back-porch clamp generator: sync edge detection, delay and
// width timing, and clamp source selection. One strobe serves all three
// colour channels.
// Assumes: the pixel clock domain throughout; the sync is synchronous.
module bp_clamp_gen
    import bp_clamp_pkg::*;
#(
    parameter int unsigned CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             hs_active_low,
    input  logic [CNT_W-1:0] delay_cfg,
    input  logic [CNT_W-1:0] width_cfg,
    input  logic             use_ext,
    input  logic             ext_clamp_in,
    output logic             clamp_out,
    output logic             pulse_active
);

    logic trail;

    bp_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_raw  (hsync_in),
        .act_low (hs_active_low),
        .trail   (trail)
    );

    bp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .trail  (trail),
        .dly_in (delay_cfg),
        .wid_in (width_cfg),
        .active (pulse_active)
    );

    bp_clamp_sel u_sel (
        .use_ext   (use_ext),
        .ext_clamp (ext_clamp_in),
        .int_pulse (pulse_active),
        .clamp     (clamp_out)
    );

endmodule

// File: rtl/bp_clamp_gen_chk.sv
// Port-level checker for bp_clamp_gen. It keeps its own record of the
// normalized sync to see trailing edges, then relates them to the pulse.
// Assumes: bound to every instance of bp_clamp_gen.
module bp_clamp_gen_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_in,
    input logic             hs_active_low,
    input logic [CNT_W-1:0] delay_cfg,
    input logic [CNT_W-1:0] width_cfg,
    input logic             use_ext,
    input logic             ext_clamp_in,
    input logic             clamp_out,
    input logic             pulse_active
);

    logic seen_now_q;
    logic seen_prev_q;
    logic seen_trail;

    // Observe the sync level and its history at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_now_q  <= 1'b0;
            seen_prev_q <= 1'b0;
        end else begin
            seen_now_q  <= hsync_in ^ hs_active_low;
            seen_prev_q <= seen_now_q;
        end
    end

    always_comb begin
        seen_trail = seen_prev_q & ~seen_now_q;
    end

    // R1: reset clears the pulse.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !pulse_active);

    // R3: a zero width at capture yields no pulse.
    p_zero_width_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_trail && width_cfg == '0) |=> !pulse_active);

    // R4: a zero delay at capture starts the pulse at once.
    p_zero_delay_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_trail && delay_cfg == '0 && width_cfg != '0) |=> pulse_active);

    // R6: a new edge with a nonzero delay abandons any running pulse.
    p_restart_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_trail && delay_cfg != '0) |=> !pulse_active);

    // R8: with the internal source selected, the strobe follows the pulse.
    p_internal_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !use_ext |-> (clamp_out == pulse_active));

    // R8: with the external source selected, the strobe follows the pin.
    p_external_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        use_ext |-> (clamp_out == ext_clamp_in));

endmodule

bind bp_clamp_gen bp_clamp_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hsync_in      (hsync_in),
    .hs_active_low (hs_active_low),
    .delay_cfg     (delay_cfg),
    .width_cfg     (width_cfg),
    .use_ext       (use_ext),
    .ext_clamp_in  (ext_clamp_in),
    .clamp_out     (clamp_out),
    .pulse_active  (pulse_active)
);

// File: tb/sim_bp_clamp_gen.sv
// Self-checking bench for bp_clamp_gen: directed corner lines plus seeded
// random lines, compared every cycle against a window model.
module sim_bp_clamp_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_act = 1'b0;
    logic       hs_active_low = 1'b0;
    logic [7:0] delay_cfg = 8'h80;
    logic [7:0] width_cfg = 8'h80;
    logic       use_ext = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic       hsync_in;
    logic       clamp_out;
    logic       pulse_active;

    assign hsync_in = hs_act ^ hs_active_low;

    always #4 clk = ~clk;

    bp_clamp_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_in      (hsync_in),
        .hs_active_low (hs_active_low),
        .delay_cfg     (delay_cfg),
        .width_cfg     (width_cfg),
        .use_ext       (use_ext),
        .ext_clamp_in  (ext_clamp_in),
        .clamp_out     (clamp_out),
        .pulse_active  (pulse_active)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Model state (bench side, derived from the requirements).
    longint cyc = 0;
    bit     prev_lvl = 0;
    bit     pend = 0;
    longint pend_n = 0;
    bit     valid = 0;
    longint base_n = 0;
    int     cap_d = 0;
    int     cap_w = 0;

    function automatic bit exp_pulse(longint t, bit v, longint b, int d, int w);
        if (!v || w == 0) return 1'b0;
        return (t >= b + 1 + d) && (t < b + 1 + d + w);
    endfunction

    task automatic check_bit(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    // Advance the model at each edge, then compare away from the edge.
    always @(posedge clk) begin
        bit lvl;
        bit e;
        cyc++;
        lvl = hsync_in ^ hs_active_low;
        if (!rst_n) begin
            valid = 0; pend = 0; prev_lvl = 0;
        end else begin
            if (pend && cyc == pend_n + 1) begin
                base_n = pend_n; cap_d = delay_cfg; cap_w = width_cfg;
                valid = 1; pend = 0;
            end
            if (prev_lvl && !lvl) begin
                pend = 1; pend_n = cyc;
            end
            prev_lvl = lvl;
        end
        #2;
        e = exp_pulse(cyc, valid, base_n, cap_d, cap_w);
        check_bit(rst_n ? cur_req : "R1", pulse_active, e);
        check_bit(use_ext ? "R8 external" : "R8 internal", clamp_out,
                  use_ext ? ext_clamp_in : e);
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One line: sync active for s cycles, then inactive for rest cycles,
    // optionally rewriting the configuration mid-line (R5).
    task automatic line(int d, int w, int s, int rest, bit mid_write);
        delay_cfg = 8'(d); width_cfg = 8'(w);
        @(negedge clk); hs_act = 1'b1;
        idle(s);
        hs_act = 1'b0;
        for (int i = 0; i < rest; i++) begin
            @(negedge clk);
            if (mid_write && i == 3) begin
                delay_cfg = 8'($urandom_range(0, 255));
                width_cfg = 8'($urandom_range(0, 255));
            end
            if (cur_req == "R9") begin
                use_ext = $urandom_range(0, 1);
                ext_clamp_in = $urandom_range(0, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cur_req = "R1";
        idle(5);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";  line(10, 5, 8, 40, 0);
        line(1, 1, 3, 20, 0);
        cur_req = "R4";  line(0, 3, 4, 20, 0);
        line(0, 1, 2, 12, 0);
        cur_req = "R3";  line(0, 0, 4, 30, 0);
        line(7, 0, 4, 30, 0);
        cur_req = "R5";  line(12, 9, 5, 50, 1);
        line(2, 20, 5, 50, 1);
        cur_req = "R6";  line(20, 10, 4, 15, 0);   // cut before the pulse
        line(3, 30, 4, 12, 0);                     // cut during the pulse
        line(5, 4, 4, 30, 0);
        cur_req = "R7";
        hs_active_low = 1'b1;                      // same level, no edge
        line(6, 6, 5, 30, 0);
        line(0, 2, 3, 20, 0);
        hs_active_low = 1'b0;
        idle(3);
        cur_req = "R10"; line(255, 255, 6, 530, 0);
        cur_req = "R9";  line(4, 25, 5, 50, 0);
        use_ext = 1'b0; ext_clamp_in = 1'b0;

        cur_req = "R1";                             // reset mid-pulse
        line(2, 40, 3, 10, 0);
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(20);

        cur_req = "R2";
        for (int k = 0; k < 150; k++) begin
            int d;
            int w;
            d = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 40);
            w = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 60);
            if (k % 3 == 0) cur_req = "R5";
            else if (k % 3 == 1) cur_req = "R6";
            else cur_req = "R9";
            line(d, w, $urandom_range(1, 12), $urandom_range(5, 320),
                 $urandom_range(0, 1));
        end
        use_ext = 1'b0;
        idle(10);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog cycle %0d actual running expected done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule